// File: doc/BRIEF.md
# DRAM Power-Up Initialization Sequencer

This block takes an external DDR-class memory from power-on to normal operation. After a start request it switches on the PHY delay-locked loop, starts it, and waits for the PHY to report lock. When the DLL-off option is chosen, it can freeze the delay line from part of the reported lock value and then turn the DLL off. It waits until the power-up clock interval has passed, then drives a command phase for each memory chip. Each phase is a NOP that raises clock-enable, a mode-register set, a settling wait, and mode-register reads repeated until the device reports that its auto-initialization is finished.

When every configured chip has finished, refresh is enabled. Power-down modes may be enabled one cycle later, and a one-cycle completion pulse is issued. If the DLL does not lock, or the status polling runs too long, the sequence stops in a sticky error state. Both waits come from one shared down-counter whose load values are derived from the clock frequency parameter.

Top module: `dram_init_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, every output is low: the command strobes, chip select, CKE, the DLL controls, the force value, refresh, power-down, done and error.
- R2: A start request seen in the idle state raises `dll_en_o` in the next cycle and `dll_start_o` one cycle after that. A start request seen in any other state is ignored.
- R3: No command strobe is issued before `dll_locked_i` has been seen high. If lock does not arrive within `LOCK_TMO` cycles, `err_o` goes high and stays high, and no command is ever issued.
- R4: When `dll_off_mode_i` was high at start, `dll_force_o` is loaded with bits [9:2] of `dll_lock_val_i` (bit 9 goes to the MSB) in the cycle before `dll_en_o` falls. When the option is low, `dll_en_o` stays high and `dll_force_o` stays zero.
- R5: The first NOP is not issued until at least `PWRUP_US*CLK_MHZ` clock cycles have passed since reset was released.
- R6: CKE stays low until the first NOP, rises in the cycle after it, and never falls again.
- R7: In each chip phase, an MRS follows the NOP in the next cycle. The first MRR comes no earlier than `MRS_US*CLK_MHZ` cycles after the MRS.
- R8: When a response arrives (`mrr_valid_i` high) with `mrr_dai_i` low, another MRR is issued. The phase ends on the first response with `mrr_dai_i` high, so each chip sees one MRR more than it had not-ready responses.
- R9: If a chip's polling has not finished within `POLL_TMO` cycles of its first MRR, `err_o` goes high and stays high. Refresh, power-down and done stay low.
- R10: When `two_chip_i` was high at start, a second full phase (NOP, MRS, MRR polling) runs with `cs_o`=1 after chip 0 completes with `cs_o`=0. Otherwise only chip 0 is initialized.
- R11: `ref_en_o` rises only after the final chip's phase is complete, and no command follows it. `done_o` pulses for exactly one cycle, in the cycle in which `ref_en_o` first reads high. `pd_en_o` rises one cycle later.
- R12: At most one of the three command strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled in idle |
| dll_locked_i | input | 1 | PHY DLL lock flag |
| dll_lock_val_i | input | 10 | Lock value reported by the PHY |
| dll_off_mode_i | input | 1 | Freeze the delay and turn the DLL off after lock (latched at start) |
| two_chip_i | input | 1 | Initialize a second chip (latched at start) |
| mrr_valid_i | input | 1 | Mode-register read response strobe |
| mrr_dai_i | input | 1 | Auto-initialization-complete bit of the response |
| cmd_nop_o | output | 1 | NOP command strobe |
| cmd_mrs_o | output | 1 | Mode-register-set command strobe |
| cmd_mrr_o | output | 1 | Mode-register-read command strobe |
| cs_o | output | 1 | Chip targeted by the current phase |
| cke_o | output | 1 | Memory clock enable |
| dll_en_o | output | 1 | DLL enable |
| dll_start_o | output | 1 | DLL start |
| dll_force_o | output | 8 | Frozen delay value for DLL-off operation |
| ref_en_o | output | 1 | Auto-refresh counter enable |
| pd_en_o | output | 1 | Power-down modes permitted |
| done_o | output | 1 | One-cycle pulse on successful completion |
| err_o | output | 1 | Sticky timeout error |

## Verification
The sequencer is tried with one chip and with two, with the DLL left on and with DLL-off mode, and with zero to three not-ready poll responses per chip at random response latencies. These runs separate a wrong per-chip poll count, a missed chip-select change, and a force value taken from the wrong bit slice. A DLL that never locks and a device that never reports ready drive the two timeout paths, which shows that the error exit issues no commands and no refresh. Lock arrives at random delays, and start is pulsed again after completion, to show that commands wait for lock and that a late start has no effect.

// File: rtl/dram_init_pkg.sv
package dram_init_pkg;

  localparam int LOCK_W  = 10;
  localparam int FORCE_W = 8;

  typedef enum logic [3:0] {
    S_IDLE,
    S_DLL_EN,
    S_DLL_GO,
    S_LOCK,
    S_FORCE,
    S_DLL_OFF,
    S_PWR,
    S_NOP,
    S_MRS,
    S_MRS_WT,
    S_MRR,
    S_MRR_WT,
    S_REF,
    S_DONE,
    S_RUN,
    S_ERR
  } seq_st_e;

  // wait length in clock cycles for a delay given in microseconds
  function automatic int unsigned us_to_cycles(int unsigned us, int unsigned mhz);
    return us * mhz;
  endfunction

  // frozen delay taken from the upper bits of the lock value
  function automatic logic [FORCE_W-1:0] force_slice(logic [LOCK_W-1:0] v);
    return v[LOCK_W-1:LOCK_W-FORCE_W];
  endfunction

endpackage

// File: rtl/dram_init_timer.sv
module dram_init_timer #(
  parameter int unsigned INIT_CYC   = 16,
  parameter int unsigned RELOAD_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic expired_o
);

  localparam int unsigned MAXV = (INIT_CYC > RELOAD_CYC) ? INIT_CYC : RELOAD_CYC;
  localparam int CW = $clog2(MAXV + 1);

  logic [CW-1:0] cnt_q;

  // starts at the power-up interval on reset; reloads with the settle interval
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CW'(INIT_CYC);
    end else if (load_i) begin
      cnt_q <= CW'(RELOAD_CYC);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/dram_init_wdog.sv
module dram_init_wdog #(
  parameter int unsigned LIMIT_A = 64,
  parameter int unsigned LIMIT_B = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic sel_a_i,
  output logic tmo_o
);

  localparam int unsigned MAXV = (LIMIT_A > LIMIT_B) ? LIMIT_A : LIMIT_B;
  localparam int CW = $clog2(MAXV + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;

  assign limit = sel_a_i ? CW'(LIMIT_A) : CW'(LIMIT_B);
  assign tmo_o = run_i && (cnt_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run_i) begin
      cnt_q <= '0;
    end else if (cnt_q < limit) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

endmodule

// File: rtl/dram_init_seq.sv
module dram_init_seq
  import dram_init_pkg::*;
#(
  parameter int unsigned CLK_MHZ  = 400,
  parameter int unsigned PWRUP_US = 200,
  parameter int unsigned MRS_US   = 1,
  parameter int unsigned LOCK_TMO = 4096,
  parameter int unsigned POLL_TMO = 4096
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               dll_locked_i,
  input  logic [LOCK_W-1:0]  dll_lock_val_i,
  input  logic               dll_off_mode_i,
  input  logic               two_chip_i,
  input  logic               mrr_valid_i,
  input  logic               mrr_dai_i,
  output logic               cmd_nop_o,
  output logic               cmd_mrs_o,
  output logic               cmd_mrr_o,
  output logic               cs_o,
  output logic               cke_o,
  output logic               dll_en_o,
  output logic               dll_start_o,
  output logic [FORCE_W-1:0] dll_force_o,
  output logic               ref_en_o,
  output logic               pd_en_o,
  output logic               done_o,
  output logic               err_o
);

  localparam int unsigned PWRUP_CYC = us_to_cycles(PWRUP_US, CLK_MHZ);
  localparam int unsigned MRS_CYC   = us_to_cycles(MRS_US, CLK_MHZ);

  seq_st_e st_q, st_d;
  logic chip_q, two_q, off_q;
  logic cke_q, dll_en_q, dll_go_q, ref_q, pd_q;
  logic [FORCE_W-1:0] force_q;

  // named internal events
  logic wait_done;
  logic tmo;
  logic wd_run;
  logic force_ld_ev;
  logic chip_done_ev;
  logic last_chip;

  assign force_ld_ev  = (st_q == S_FORCE);
  assign chip_done_ev = (st_q == S_MRR_WT) && mrr_valid_i && mrr_dai_i;
  assign last_chip    = !two_q || chip_q;
  assign wd_run       = (st_q == S_LOCK) || (st_q == S_MRR) || (st_q == S_MRR_WT);

  dram_init_timer #(
    .INIT_CYC  (PWRUP_CYC),
    .RELOAD_CYC(MRS_CYC)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (st_q == S_MRS),
    .expired_o(wait_done)
  );

  dram_init_wdog #(
    .LIMIT_A(LOCK_TMO),
    .LIMIT_B(POLL_TMO)
  ) u_wdog (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (wd_run),
    .sel_a_i(st_q == S_LOCK),
    .tmo_o  (tmo)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE:    if (start_i) st_d = S_DLL_EN;
      S_DLL_EN:  st_d = S_DLL_GO;
      S_DLL_GO:  st_d = S_LOCK;
      S_LOCK: begin
        if (dll_locked_i) st_d = off_q ? S_FORCE : S_PWR;
        else if (tmo)     st_d = S_ERR;
      end
      S_FORCE:   st_d = S_DLL_OFF;
      S_DLL_OFF: st_d = S_PWR;
      S_PWR:     if (wait_done) st_d = S_NOP;
      S_NOP:     st_d = S_MRS;
      S_MRS:     st_d = S_MRS_WT;
      S_MRS_WT:  if (wait_done) st_d = S_MRR;
      S_MRR:     st_d = S_MRR_WT;
      S_MRR_WT: begin
        if (chip_done_ev)     st_d = last_chip ? S_REF : S_NOP;
        else if (mrr_valid_i) st_d = S_MRR;
        else if (tmo)         st_d = S_ERR;
      end
      S_REF:     st_d = S_DONE;
      S_DONE:    st_d = S_RUN;
      S_RUN:     st_d = S_RUN;
      S_ERR:     st_d = S_ERR;
      default:   st_d = S_ERR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      chip_q   <= 1'b0;
      two_q    <= 1'b0;
      off_q    <= 1'b0;
      cke_q    <= 1'b0;
      dll_en_q <= 1'b0;
      dll_go_q <= 1'b0;
      ref_q    <= 1'b0;
      pd_q     <= 1'b0;
      force_q  <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == S_IDLE && start_i) begin
        two_q    <= two_chip_i;
        off_q    <= dll_off_mode_i;
        dll_en_q <= 1'b1;
      end
      if (st_q == S_DLL_EN) dll_go_q <= 1'b1;
      if (st_q == S_LOCK && dll_locked_i && off_q) force_q <= force_slice(dll_lock_val_i);
      if (st_q == S_FORCE) dll_en_q <= 1'b0;
      if (st_q == S_NOP) cke_q <= 1'b1;
      if (chip_done_ev && !last_chip) chip_q <= 1'b1;
      if (st_q == S_REF) ref_q <= 1'b1;
      if (st_q == S_DONE) pd_q <= 1'b1;
    end
  end

  assign cmd_nop_o   = (st_q == S_NOP);
  assign cmd_mrs_o   = (st_q == S_MRS);
  assign cmd_mrr_o   = (st_q == S_MRR);
  assign cs_o        = chip_q;
  assign cke_o       = cke_q;
  assign dll_en_o    = dll_en_q;
  assign dll_start_o = dll_go_q;
  assign dll_force_o = force_q;
  assign ref_en_o    = ref_q;
  assign pd_en_o     = pd_q;
  assign done_o      = (st_q == S_DONE);
  assign err_o       = (st_q == S_ERR);

endmodule

// File: rtl/dram_init_seq_chk.sv
module dram_init_seq_chk #(
  parameter int unsigned CLK_MHZ  = 400,
  parameter int unsigned PWRUP_US = 200,
  parameter int unsigned MRS_US   = 1
) (
  input logic clk,
  input logic rst_n,
  input logic dll_locked_i,
  input logic cmd_nop_o,
  input logic cmd_mrs_o,
  input logic cmd_mrr_o,
  input logic cke_o,
  input logic dll_en_o,
  input logic dll_start_o,
  input logic ref_en_o,
  input logic pd_en_o,
  input logic done_o,
  input logic err_o,
  input logic force_ld_ev
);

  localparam int unsigned PWRUP_CYC = dram_init_pkg::us_to_cycles(PWRUP_US, CLK_MHZ);
  localparam int unsigned MRS_CYC   = dram_init_pkg::us_to_cycles(MRS_US, CLK_MHZ);

  int unsigned since_rst;
  int unsigned since_mrs;
  logic        lock_seen;
  logic        any_cmd;

  assign any_cmd = cmd_nop_o || cmd_mrs_o || cmd_mrr_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst <= 0;
      since_mrs <= 0;
      lock_seen <= 1'b0;
    end else begin
      if (since_rst < PWRUP_CYC) since_rst <= since_rst + 1;
      if (cmd_mrs_o) since_mrs <= 1;
      else if (since_mrs != 0 && since_mrs < MRS_CYC) since_mrs <= since_mrs + 1;
      if (dll_locked_i && dll_start_o) lock_seen <= 1'b1;
    end
  end

  // R2
  dll_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dll_start_o) |-> dll_en_o);

  // R3
  lock_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_cmd |-> lock_seen);

  // R4
  force_before_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dll_en_o) |-> $past(force_ld_ev));

  // R5
  pwrup_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_nop_o |-> since_rst >= PWRUP_CYC);

  // R6
  nop_then_cke_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_nop_o |=> cke_o);

  // R6
  cke_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cke_o |=> cke_o);

  // R6
  cke_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke_o) |-> $past(cmd_nop_o));

  // R7
  mrs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_mrr_o |-> since_mrs >= MRS_CYC);

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o && !any_cmd && !ref_en_o);

  // R11
  ref_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_en_o |-> !any_cmd);

  // R11
  pd_after_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_en_o) |-> $past(ref_en_o) && $past(done_o));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R12
  one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_nop_o, cmd_mrs_o, cmd_mrr_o}));

endmodule

bind dram_init_seq dram_init_seq_chk #(
  .CLK_MHZ (CLK_MHZ),
  .PWRUP_US(PWRUP_US),
  .MRS_US  (MRS_US)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .dll_locked_i(dll_locked_i),
  .cmd_nop_o   (cmd_nop_o),
  .cmd_mrs_o   (cmd_mrs_o),
  .cmd_mrr_o   (cmd_mrr_o),
  .cke_o       (cke_o),
  .dll_en_o    (dll_en_o),
  .dll_start_o (dll_start_o),
  .ref_en_o    (ref_en_o),
  .pd_en_o     (pd_en_o),
  .done_o      (done_o),
  .err_o       (err_o),
  .force_ld_ev (force_ld_ev)
);

// File: tb/dram_init_seq_test.sv
module dram_init_seq_test;

  localparam int CLK_MHZ  = 4;
  localparam int PWRUP_US = 10;
  localparam int MRS_US   = 3;
  localparam int LOCK_TMO = 30;
  localparam int POLL_TMO = 60;
  localparam int P_CYC    = PWRUP_US * CLK_MHZ;
  localparam int M_CYC    = MRS_US * CLK_MHZ;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, dll_locked_i = 1'b0, dll_off_mode_i = 1'b0, two_chip_i = 1'b0;
  logic [9:0] dll_lock_val_i = '0;
  logic mrr_valid_i = 1'b0, mrr_dai_i = 1'b0;
  logic cmd_nop_o, cmd_mrs_o, cmd_mrr_o, cs_o, cke_o, dll_en_o, dll_start_o;
  logic [7:0] dll_force_o;
  logic ref_en_o, pd_en_o, done_o, err_o;

  always #2 clk = ~clk;

  dram_init_seq #(
    .CLK_MHZ(CLK_MHZ), .PWRUP_US(PWRUP_US), .MRS_US(MRS_US),
    .LOCK_TMO(LOCK_TMO), .POLL_TMO(POLL_TMO)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dll_locked_i(dll_locked_i),
    .dll_lock_val_i(dll_lock_val_i), .dll_off_mode_i(dll_off_mode_i),
    .two_chip_i(two_chip_i), .mrr_valid_i(mrr_valid_i), .mrr_dai_i(mrr_dai_i),
    .cmd_nop_o(cmd_nop_o), .cmd_mrs_o(cmd_mrs_o), .cmd_mrr_o(cmd_mrr_o),
    .cs_o(cs_o), .cke_o(cke_o), .dll_en_o(dll_en_o), .dll_start_o(dll_start_o),
    .dll_force_o(dll_force_o), .ref_en_o(ref_en_o), .pd_en_o(pd_en_o),
    .done_o(done_o), .err_o(err_o)
  );

  int total = 0, failed = 0;
  int gcyc = 0;

  // monitor state
  int cyc, nop_n, mrs_n, first_nop, last_mrs, min_gap, ref_rise, pd_rise;
  int done_n, done_at, en_rise, en_fall, st_rise;
  int mrr_n[2];
  bit cke_early, cke_fell, cke_after, cs_bad, pre_lock, after_ref, multi, mrr_orphan;
  bit cke_prev, en_prev, st_prev, ref_seen;
  logic [7:0] force_at_fall;

  // responder state
  int polls_cfg, polls_left, pend;
  bit never_dai;

  function automatic logic [7:0] exp_force(logic [9:0] v);
    return 8'((v >> 2) & 10'h0FF);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic mon_clear();
    cyc = 0; nop_n = 0; mrs_n = 0; first_nop = -1; last_mrs = -100000; min_gap = 100000;
    ref_rise = -1; pd_rise = -1; done_n = 0; done_at = -1; en_rise = -1; en_fall = -1;
    st_rise = -1; mrr_n[0] = 0; mrr_n[1] = 0;
    cke_early = 0; cke_fell = 0; cke_after = 0; cs_bad = 0; pre_lock = 0;
    after_ref = 0; multi = 0; mrr_orphan = 0;
    cke_prev = 0; en_prev = 0; st_prev = 0; ref_seen = 0; force_at_fall = '0;
  endtask

  // samples just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      gcyc++;
      if (rst_n) begin
        int strobes;
        cyc++;
        strobes = int'(cmd_nop_o) + int'(cmd_mrs_o) + int'(cmd_mrr_o);
        if (strobes > 1) multi = 1;
        if (strobes != 0 && !dll_locked_i) pre_lock = 1;
        if (strobes != 0 && ref_seen) after_ref = 1;
        if (cmd_nop_o) begin
          nop_n++;
          if (first_nop < 0) first_nop = cyc;
          if (int'(cs_o) != nop_n - 1) cs_bad = 1;
        end
        if (cke_o && nop_n == 0) cke_early = 1;
        if (!cke_o && cke_prev) cke_fell = 1;
        if (first_nop >= 0 && cyc == first_nop + 1) cke_after = cke_o;
        if (cmd_mrs_o) begin mrs_n++; last_mrs = cyc; end
        if (cmd_mrr_o) begin
          mrr_n[cs_o]++;
          if (mrs_n == 0) mrr_orphan = 1;
          if (cyc - last_mrs < min_gap) min_gap = cyc - last_mrs;
        end
        if (dll_en_o && !en_prev) en_rise = cyc;
        if (!dll_en_o && en_prev) begin en_fall = cyc; force_at_fall = dll_force_o; end
        if (dll_start_o && !st_prev) st_rise = cyc;
        if (ref_en_o && !ref_seen) begin ref_rise = cyc; ref_seen = 1; end
        if (pd_en_o && pd_rise < 0) pd_rise = cyc;
        if (done_o) begin done_n++; done_at = cyc; end
        cke_prev = cke_o; en_prev = dll_en_o; st_prev = dll_start_o;
      end
    end
  end

  // memory model answering mode-register reads
  initial begin
    forever begin
      @(negedge clk);
      mrr_valid_i = 1'b0;
      mrr_dai_i = 1'b0;
      if (!rst_n) begin
        pend = 0;
      end else begin
        if (cmd_nop_o) polls_left = polls_cfg;
        if (pend > 0) begin
          pend--;
          if (pend == 0) begin
            mrr_valid_i = 1'b1;
            mrr_dai_i = !never_dai && polls_left == 0;
            if (!mrr_dai_i) polls_left--;
          end
        end
        if (cmd_mrr_o) pend = 1 + int'($urandom % 3);
      end
    end
  end

  task automatic run(int two, int off, int polls, int lock_dly, bit no_lock, bit nodai,
                     logic [9:0] lv, string tag);
    int s, ld, en_before;
    rst_n = 1'b0; start_i = 0; dll_locked_i = 0; dll_lock_val_i = lv;
    dll_off_mode_i = off[0]; two_chip_i = two[0];
    polls_cfg = polls; polls_left = polls; never_dai = nodai;
    repeat (3) @(negedge clk);
    mon_clear();
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({cmd_nop_o, cmd_mrs_o, cmd_mrr_o, cs_o, cke_o, dll_en_o, dll_start_o,
         ref_en_o, pd_en_o, done_o, err_o} == '0 && dll_force_o == '0,
        {"R1 reset outputs ", tag}, int'(cke_o), 0);
    @(negedge clk);
    start_i = 1'b1; s = cyc;
    @(negedge clk);
    start_i = 1'b0;
    ld = lock_dly;
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      if (!no_lock && dll_start_o && !dll_locked_i) begin
        if (ld == 0) dll_locked_i = 1'b1; else ld--;
      end
      if (pd_en_o || err_o) break;
    end
    repeat (3) @(negedge clk);
    // R2 enable then start ordering
    chk(en_rise == s + 1 && st_rise == s + 2, {"R2 dll order ", tag}, st_rise - en_rise, 1);
    // R12 one strobe per cycle
    chk(!multi, {"R12 single strobe ", tag}, int'(multi), 0);
    if (no_lock) begin
      // R3 lock timeout
      chk(err_o == 1'b1 && nop_n == 0, {"R3 lock timeout ", tag}, nop_n, 0);
    end else if (nodai) begin
      // R9 poll timeout
      chk(err_o == 1'b1 && !ref_en_o && done_n == 0 && mrr_n[0] >= 2,
          {"R9 poll timeout ", tag}, int'(err_o), 1);
    end else begin
      chk(!pre_lock, {"R3 cmd before lock ", tag}, int'(pre_lock), 0);
      chk(first_nop >= P_CYC, {"R5 power-up wait ", tag}, first_nop, P_CYC);
      chk(cke_after && !cke_early && !cke_fell, {"R6 cke ", tag}, int'(cke_after), 1);
      chk(min_gap >= M_CYC && mrs_n == nop_n && !mrr_orphan, {"R7 mrs settle ", tag},
          min_gap, M_CYC);
      chk(mrr_n[0] == polls + 1, {"R8 chip0 polls ", tag}, mrr_n[0], polls + 1);
      if (two != 0)
        chk(mrr_n[1] == polls + 1 && nop_n == 2 && !cs_bad, {"R10 chip1 phase ", tag},
            mrr_n[1], polls + 1);
      else
        chk(mrr_n[1] == 0 && nop_n == 1, {"R10 single chip ", tag}, mrr_n[1], 0);
      chk(done_n == 1 && done_at == ref_rise && pd_rise == ref_rise + 1 && !after_ref,
          {"R11 completion ", tag}, pd_rise - ref_rise, 1);
      if (off != 0)
        chk(!dll_en_o && force_at_fall == exp_force(lv) && dll_force_o == exp_force(lv),
            {"R4 force then off ", tag}, int'(force_at_fall), int'(exp_force(lv)));
      else
        chk(dll_en_o && dll_force_o == '0, {"R4 dll kept on ", tag}, int'(dll_force_o), 0);
    end
    // R2 start ignored outside idle
    en_before = en_rise;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (5) @(negedge clk);
    chk(en_rise == en_before && done_n == ((no_lock || nodai) ? 0 : 1) &&
        nop_n == ((no_lock) ? 0 : nop_n) && dll_en_o == ((off != 0 && !no_lock) ? 1'b0 : 1'b1),
        {"R2 late start ignored ", tag}, en_rise, en_before);
  endtask

  initial begin
    void'($urandom(32'h1d5e_0042));
    mon_clear();
    run(0, 0, 0, 0, 0, 0, 10'h000, "basic");
    run(1, 1, 2, 5, 0, 0, 10'h2B7, "two-chip dll-off");
    run(0, 1, 3, 12, 0, 0, 10'h3FC, "dll-off slice");
    run(0, 0, 0, 0, 1, 0, 10'h155, "no lock");
    run(1, 0, 0, 3, 0, 1, 10'h0AA, "never ready");
    for (int i = 0; i < 6; i++) begin
      run(int'($urandom % 2), int'($urandom % 2), int'($urandom % 4),
          int'($urandom % 20), 0, 0, 10'($urandom), "random");
    end
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      if (gcyc > 100000) begin
        total++; failed++;
        $display("FAIL watchdog run did not finish actual=%0d expected=%0d", gcyc, 100000);
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
      end
    end
  end

endmodule